// File: doc/BRIEF.md
# Timer Event Interrupt Flag Collector

This block takes the single-cycle event pulses of one general-purpose timer and turns them into sticky status flags that software can read and clear. The events are an update (counter reload) event, a capture or compare event on each of four channels, and a trigger event. The trigger event is found by edge detection on a trigger level input. A mask register selects which flags can raise the one interrupt request line.

Flags are cleared by writing ones to them. A channel flag is also cleared as a side effect when that channel's capture register is read while the channel is in capture mode. If a channel fires again while its flag is still pending, a bit is latched in a missed-event register, and that bit is cleared by writing a one to it. The block has a small register port with a write strobe, a two-bit address, write data and combinational read data.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset the flag register (address 0), the mask register (address 1) and the missed-event register (address 2) read 0, and irq_o is low.
- R2: An evt_upd pulse sets flag bit 0 at the clock edge that samples the pulse.
- R3: An evt_cc[i] pulse sets flag bit i+1 (channels 0..3 map to bits 1..4) at the clock edge that samples the pulse.
- R4: With gated_mode low, a 0-to-1 change of trig_in sets flag bit 6 and a 1-to-0 change does not. With gated_mode high, either change sets bit 6. The previous trigger level is reset to 0.
- R5: A write to address 0 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Bits 5 and 7 always read 0.
- R6: When a set event and a write-one-clear hit the same flag in the same cycle, the flag ends up set.
- R7: A cap_rd[i] pulse with cap_mode[i] high clears flag bit i+1. With cap_mode[i] low it leaves the flag unchanged.
- R8: When evt_cc[i] and a capture-mode cap_rd[i] coincide on a channel whose flag is set, the flag stays set and no missed-event bit is recorded.
- R9: An evt_cc[i] pulse arriving while flag bit i+1 is already set (and not being read-cleared) sets missed-event bit i+1 at the same edge. A write of 1 to that position of address 2 clears it, and a write of 0 leaves it. Other missed-event bits read 0.
- R10: irq_o is high exactly when some flag bit and the same mask bit are both 1, in the same cycle as the flag and mask register values. The mask is written whole at address 1, and only bits 0..4 and 6 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_upd | input | 1 | Update event pulse |
| evt_cc | input | 4 | Per-channel capture/compare event pulses |
| trig_in | input | 1 | Trigger level input |
| gated_mode | input | 1 | 1 = trigger flag on both edges |
| cap_mode | input | 4 | Per-channel: 1 = capture mode, 0 = compare mode |
| cap_rd | input | 4 | Per-channel capture register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 flags, 1 mask, 2 missed) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
Every set, clear, missed-event and mask change takes effect at the clock edge that samples the pulse or write strobe. That is one register stage, with no further delay. The trigger edge is compared against a level registered at the previous edge, so the edge is seen in the same cycle that trig_in changes. irq_o and reg_rdata come from combinational logic on the registers, so they are valid right after that edge. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. It removes each strobe before the following rising edge, so each stimulus acts on exactly one edge.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_CH   = 4;
  localparam int UPD_BIT  = 0;
  localparam int CH_LSB   = 1;
  localparam int TRIG_BIT = 6;

  typedef enum logic [1:0] {
    ADDR_FLAGS = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_MISS  = 2'd2
  } reg_addr_e;

  localparam logic [REG_W-1:0] CH_BITS   = REG_W'(((1 << NUM_CH) - 1) << CH_LSB);
  localparam logic [REG_W-1:0] FLAG_IMPL = CH_BITS | REG_W'(1 << UPD_BIT) | REG_W'(1 << TRIG_BIT);
  localparam logic [REG_W-1:0] MISS_IMPL = CH_BITS;
endpackage

// File: rtl/tmr_trig_edge.sv
module tmr_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic both_i,
  output logic pulse_o
);
  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d   = trig_i;
    pulse_o = both_i ? (trig_i ^ lvl_q) : (trig_i & ~lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/tmr_sticky_bits.sv
module tmr_sticky_bits #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_live
      logic q;
      logic d;
      always_comb d = set_i[b] | (q & ~clr_i[b]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
      end
      assign q_o[b] = q;
    end else begin : g_tie
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_upd,
  input  logic [NUM_CH-1:0] evt_cc,
  input  logic              trig_in,
  input  logic              gated_mode,
  input  logic [NUM_CH-1:0] cap_mode,
  input  logic [NUM_CH-1:0] cap_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_o
);
  logic             trig_evt;
  logic [REG_W-1:0] flags_q, miss_q, mask_q, mask_d;
  logic [REG_W-1:0] flag_set, flag_clr, miss_set, miss_clr;
  logic             mask_en;
  logic [NUM_CH-1:0] rd_clr;

  tmr_trig_edge u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_in),
    .both_i (gated_mode),
    .pulse_o(trig_evt)
  );

  always_comb begin
    rd_clr   = cap_rd & cap_mode;
    flag_set = '0;
    flag_clr = (reg_wr && reg_addr == ADDR_FLAGS) ? reg_wdata : '0;
    miss_set = '0;
    miss_clr = (reg_wr && reg_addr == ADDR_MISS) ? reg_wdata : '0;
    flag_set[UPD_BIT]  = evt_upd;
    flag_set[TRIG_BIT] = trig_evt;
    for (int i = 0; i < NUM_CH; i++) begin
      flag_set[CH_LSB+i] = evt_cc[i];
      flag_clr[CH_LSB+i] = flag_clr[CH_LSB+i] | rd_clr[i];
      miss_set[CH_LSB+i] = evt_cc[i] & flags_q[CH_LSB+i] & ~rd_clr[i];
    end
  end

  tmr_sticky_bits #(.W(REG_W), .IMPL(FLAG_IMPL)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .q_o(flags_q)
  );

  tmr_sticky_bits #(.W(REG_W), .IMPL(MISS_IMPL)) u_miss (
    .clk(clk), .rst_n(rst_n), .set_i(miss_set), .clr_i(miss_clr), .q_o(miss_q)
  );

  always_comb begin
    mask_en = reg_wr && (reg_addr == ADDR_MASK);
    mask_d  = reg_wdata & FLAG_IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_comb begin
    case (reg_addr)
      ADDR_FLAGS: reg_rdata = flags_q;
      ADDR_MASK:  reg_rdata = mask_q;
      ADDR_MISS:  reg_rdata = miss_q;
      default:    reg_rdata = '0;
    endcase
    irq_o = |(flags_q & mask_q);
  end
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk
  import tmr_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              evt_upd,
  input logic [NUM_CH-1:0] evt_cc,
  input logic              trig_in,
  input logic [NUM_CH-1:0] cap_mode,
  input logic [NUM_CH-1:0] cap_rd,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  flags,
  input logic [REG_W-1:0]  miss,
  input logic              irq_o
);
  AST_UPD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_upd |=> flags[UPD_BIT]); // R2

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(evt_upd) || $past(|evt_cc) || $past(trig_in) || $past(trig_in, 2)
                      || $past(reg_wr && reg_addr == ADDR_MASK))); // R10

  AST_FLAGS_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~FLAG_IMPL) == '0); // R5

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_CH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_cc[i] |=> flags[CH_LSB+i]); // R3

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[CH_LSB+i] && !(cap_rd[i] && cap_mode[i])
       && !(reg_wr && reg_addr == ADDR_FLAGS && reg_wdata[CH_LSB+i])) |=> flags[CH_LSB+i]); // R7

    AST_MISS_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miss[CH_LSB+i]) |-> ($past(flags[CH_LSB+i]) && $past(evt_cc[i]))); // R9

    AST_NO_MISS_ON_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
      (!miss[CH_LSB+i] && evt_cc[i] && cap_rd[i] && cap_mode[i]) |=> !miss[CH_LSB+i]); // R8
  end
endmodule

bind tmr_irq_flags tmr_irq_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_upd(evt_upd), .evt_cc(evt_cc), .trig_in(trig_in),
  .cap_mode(cap_mode), .cap_rd(cap_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .flags(flags_q), .miss(miss_q), .irq_o(irq_o)
);

// File: tb/test_tmr_irq_flags.sv
`timescale 1ns/1ps
module test_tmr_irq_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_upd = 1'b0;
  logic [3:0] evt_cc = '0;
  logic       trig_in = 1'b0;
  logic       gated_mode = 1'b0;
  logic [3:0] cap_mode = '0;
  logic [3:0] cap_rd = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tmr_irq_flags i_tmr_irq_flags (
    .clk(clk), .rst_n(rst_n), .evt_upd(evt_upd), .evt_cc(evt_cc), .trig_in(trig_in),
    .gated_mode(gated_mode), .cap_mode(cap_mode), .cap_rd(cap_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    evt_upd = 0; evt_cc = '0; cap_rd = '0; reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d; step();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(0, v); chk("R1 flags", v, 8'h00);
    rd(1, v); chk("R1 mask", v, 8'h00);
    rd(2, v); chk("R1 miss", v, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_update();
    logic [7:0] v;
    @(negedge clk); evt_upd = 1; step();
    rd(0, v); chk("R2 update flag", v, 8'h01);
    wr(0, 8'h01); rd(0, v); chk("R5 clear update", v, 8'h00);
  endtask

  task automatic t_channels();
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); evt_cc[i] = 1; step();
      rd(0, v); chk("R3 channel flag", v, 8'(1 << (i + 1)));
      wr(0, 8'hFF);
    end
  endtask

  task automatic t_trigger();
    logic [7:0] v;
    @(negedge clk); trig_in = 1; step();
    rd(0, v); chk("R4 normal rise", v, 8'h40);
    wr(0, 8'h40);
    @(negedge clk); trig_in = 0; step();
    rd(0, v); chk("R4 normal fall ignored", v, 8'h00);
    gated_mode = 1;
    @(negedge clk); trig_in = 1; step();
    rd(0, v); chk("R4 gated rise", v, 8'h40);
    wr(0, 8'h40);
    @(negedge clk); trig_in = 0; step();
    rd(0, v); chk("R4 gated fall", v, 8'h40);
    wr(0, 8'h40);
    gated_mode = 0;
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    @(negedge clk); evt_upd = 1; evt_cc[0] = 1; step();
    rd(0, v); chk("R5 two flags", v, 8'h03);
    wr(0, 8'h02); rd(0, v); chk("R5 partial clear", v, 8'h01);
    wr(0, 8'h00); rd(0, v); chk("R5 zero write keeps", v, 8'h01);
    wr(0, 8'hFF); rd(0, v); chk("R5 full clear", v, 8'h00);
  endtask

  task automatic t_setwins();
    logic [7:0] v;
    @(negedge clk); evt_cc[2] = 1; step();
    @(negedge clk); evt_cc[2] = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 8'h08; step();
    rd(0, v); chk("R6 set beats clear", v, 8'h08);
    rd(2, v); chk("R9 miss on repeat", v, 8'h08);
    wr(2, 8'h08); wr(0, 8'hFF);
  endtask

  task automatic t_rdclr();
    logic [7:0] v;
    cap_mode = 4'b0001;
    @(negedge clk); evt_cc[0] = 1; step();
    @(negedge clk); cap_rd[0] = 1; step();
    rd(0, v); chk("R7 capture read clears", v, 8'h00);
    @(negedge clk); evt_cc[1] = 1; step();
    @(negedge clk); cap_rd[1] = 1; step();
    rd(0, v); chk("R7 compare read ignored", v, 8'h04);
    wr(0, 8'hFF); cap_mode = '0;
  endtask

  task automatic t_coinc();
    logic [7:0] v;
    cap_mode = 4'b1000;
    @(negedge clk); evt_cc[3] = 1; step();
    @(negedge clk); evt_cc[3] = 1; cap_rd[3] = 1; step();
    rd(0, v); chk("R8 flag stays", v, 8'h10);
    rd(2, v); chk("R8 no miss", v, 8'h00);
    wr(0, 8'hFF); cap_mode = '0;
  endtask

  task automatic t_miss();
    logic [7:0] v;
    @(negedge clk); evt_cc[1] = 1; step();
    @(negedge clk); evt_cc[1] = 1; step();
    rd(2, v); chk("R9 miss set", v, 8'h04);
    wr(2, 8'h00); rd(2, v); chk("R9 zero write keeps miss", v, 8'h04);
    wr(2, 8'h04); rd(2, v); chk("R9 miss cleared", v, 8'h00);
    rd(0, v); chk("R9 flag still set", v, 8'h04);
    wr(0, 8'hFF);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    @(negedge clk); evt_upd = 1; step();
    chk("R10 masked no irq", {7'd0, irq_o}, 8'h00);
    wr(1, 8'hFF); rd(1, v); chk("R10 mask stored", v, 8'h5F);
    chk("R10 irq on mask", {7'd0, irq_o}, 8'h01);
    wr(1, 8'h40);
    chk("R10 other mask bit", {7'd0, irq_o}, 8'h00);
    @(negedge clk); trig_in = 1; step();
    chk("R10 irq with flag", {7'd0, irq_o}, 8'h01);
    wr(0, 8'h40);
    chk("R10 irq drops", {7'd0, irq_o}, 8'h00);
    wr(0, 8'hFF); wr(1, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_update();
    t_channels();
    t_trigger();
    t_w1c();
    t_setwins();
    t_rdclr();
    t_coinc();
    t_miss();
    t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule